// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a small in-order processor core built as five stages: fetch, decode, execute, memory and writeback. Its register file holds eight words. It runs five working instructions: add, nand, load, store and branch-if-equal. It also has a halt and a no-op. Instruction memory and data memory sit outside the core as plain word-addressed arrays that answer in the same cycle, and every completed instruction is reported on a retire port in program order.

Branches are predicted not-taken and settle in the memory stage. A taken branch redirects fetch and turns the three younger instructions into bubbles. Operands come from the execute stage's own forwarding network, fed by the two older stages. A register written back can be read by decode in the same cycle. The only stall is one bubble after a load whose result is needed by the next instruction.

The memory ports are plain request signals rather than valid/ready streams, because both arrays always answer at once. The core never applies back-pressure and never waits, so its edge has no flow control. A halt stops fetch and raises a sticky completion flag when the halt retires.

Top module: `core_pipe5`

## Requirements
- R1: The instruction word is 25 bits. The opcode is in bits 24:22 and is coded add=0, nand=1, load=2, store=3, branch-if-equal=4, halt=6, no-op=7. The first source field (A) is bits 21:19, the second (B) is bits 18:16, the signed offset is bits 15:0 and the arithmetic destination is bits 2:0. The core fetches word PC, and PC starts at 0.
- R2: Add writes A+B into the register named by bits 2:0, and nand writes ~(A&B) there, using 32-bit wrapping arithmetic.
- R3: Load writes the data word at address A+offset into the register named by field B (bits 18:16). While the load is in the memory stage it drives dmem_en high and dmem_we low.
- R4: Store writes register B to address A+offset with dmem_en and dmem_we both high, and it writes no register.
- R5: A taken branch (A equal to B) continues at PC+1+offset. It settles in the memory stage and squashes the three younger instructions, so the next retire comes four cycles after the branch retires.
- R6: A branch that is not taken costs nothing: the next instruction retires in the following cycle.
- R7: Back-to-back dependent instructions get the newest value through forwarding, with no lost cycle. When the two older stages both hold a write to the same register, the younger one wins.
- R8: When the instruction right after a load names the load's destination in field A or field B, whatever its opcode, exactly one bubble is inserted.
- R9: An instruction three places after the producer of a register reads the value being written back in that same cycle.
- R10: A halt raises done in the cycle it retires. done then stays high, and nothing after the halt retires. A halt that a taken branch squashes has no effect.
- R11: ret_valid pulses once for each completed instruction, in program order, with its PC, a write flag, the destination and the written value.
- R12: Reset clears all eight registers to zero and sets PC to 0, with no retire and done low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| imem_addr | output | XLEN | Word address of the instruction being fetched |
| imem_data | input | 25 | Instruction word at imem_addr, same cycle |
| dmem_en | output | 1 | Data memory access this cycle |
| dmem_we | output | 1 | Data memory write (store) |
| dmem_addr | output | XLEN | Data word address |
| dmem_wdata | output | XLEN | Store data |
| dmem_rdata | input | XLEN | Load data at dmem_addr, same cycle |
| ret_valid | output | 1 | An instruction completes this cycle |
| ret_pc | output | XLEN | PC of the completing instruction |
| ret_we | output | 1 | Completing instruction writes a register |
| ret_dest | output | 3 | Register written |
| ret_data | output | XLEN | Value written |
| done | output | 1 | Halt has retired (sticky) |

## Verification
The assertions assume that both memories answer combinationally in the same cycle and that the instruction stream uses only the seven defined opcodes. Under those assumptions, squashing, stall bubbles and the quiet pipeline after a halt follow from the pipeline control alone. The stimulus meets these assumptions by serving the core from bench arrays read combinationally and by building each program only from the defined encodings. Unused instruction memory is filled with halts.

// File: rtl/core_pkg.sv
package core_pkg;
  localparam int IW = 25;

  localparam logic [2:0] OP_ADD  = 3'd0;
  localparam logic [2:0] OP_NAND = 3'd1;
  localparam logic [2:0] OP_LW   = 3'd2;
  localparam logic [2:0] OP_SW   = 3'd3;
  localparam logic [2:0] OP_BEQ  = 3'd4;
  localparam logic [2:0] OP_HALT = 3'd6;
  localparam logic [2:0] OP_NOP  = 3'd7;

  function automatic logic [2:0] f_op(input logic [IW-1:0] w);
    return w[24:22];
  endfunction

  function automatic logic [2:0] f_ra(input logic [IW-1:0] w);
    return w[21:19];
  endfunction

  function automatic logic [2:0] f_rb(input logic [IW-1:0] w);
    return w[18:16];
  endfunction

  // destination field depends on opcode: loads use field B, ALU ops bits 2:0
  function automatic logic [2:0] f_dest(input logic [IW-1:0] w);
    return (w[24:22] == OP_LW) ? w[18:16] : w[2:0];
  endfunction

  function automatic logic f_wr(input logic [2:0] op);
    return (op == OP_ADD) || (op == OP_NAND) || (op == OP_LW);
  endfunction
endpackage

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [2:0]                wa,
  input  logic [XLEN-1:0]           wd,
  input  logic [1:0][2:0]           ra,
  output logic [1:0][XLEN-1:0]      rd
);
  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wa] <= wd;
    end
  end

  // write-through: a value being written back is visible to decode now
  for (genvar p = 0; p < 2; p++) begin : g_rd
    assign rd[p] = (we && (wa == ra[p])) ? wd : regs[ra[p]];
  end
endmodule

// File: rtl/core_hazard.sv
module core_hazard import core_pkg::*; (
  input  logic            fd_v,
  input  logic [2:0]      fd_ra,
  input  logic [2:0]      fd_rb,
  input  logic            de_v,
  input  logic [2:0]      de_op,
  input  logic [2:0]      de_ra,
  input  logic [2:0]      de_rb,
  input  logic            em_fwd,
  input  logic [2:0]      em_dest,
  input  logic            mw_fwd,
  input  logic [2:0]      mw_dest,
  output logic            ld_stall,
  output logic [1:0][1:0] sel
);
  logic [1:0][2:0] src;
  assign src[0] = de_ra;
  assign src[1] = de_rb;

  // 1 = from EX/MEM (younger), 2 = from MEM/WB, 0 = decode copy
  for (genvar p = 0; p < 2; p++) begin : g_sel
    assign sel[p] = (em_fwd && em_dest == src[p]) ? 2'd1 :
                    (mw_fwd && mw_dest == src[p]) ? 2'd2 : 2'd0;
  end

  assign ld_stall = fd_v && de_v && (de_op == OP_LW) &&
                    ((fd_ra == de_rb) || (fd_rb == de_rb));
endmodule

// File: rtl/core_alu.sv
module core_alu import core_pkg::*; #(
  parameter int XLEN = 32
) (
  input  logic [2:0]      op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [XLEN-1:0] off,
  input  logic [XLEN-1:0] pc1,
  output logic [XLEN-1:0] res,
  output logic            take,
  output logic [XLEN-1:0] tgt
);
  always_comb begin
    unique case (op)
      OP_NAND:      res = ~(a & b);
      OP_LW, OP_SW: res = a + off;
      default:      res = a + b;
    endcase
  end

  assign take = (op == OP_BEQ) && (a == b);
  assign tgt  = pc1 + off;
endmodule

// File: rtl/core_pipe5.sv
module core_pipe5 import core_pkg::*; #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] imem_addr,
  input  logic [IW-1:0]   imem_data,
  output logic            dmem_en,
  output logic            dmem_we,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  input  logic [XLEN-1:0] dmem_rdata,
  output logic            ret_valid,
  output logic [XLEN-1:0] ret_pc,
  output logic            ret_we,
  output logic [2:0]      ret_dest,
  output logic [XLEN-1:0] ret_data,
  output logic            done
);
  localparam int OFFW = 16;

  logic [XLEN-1:0] pc;
  logic            stop_q, done_q;

  logic            fd_v;
  logic [IW-1:0]   fd_ins;
  logic [XLEN-1:0] fd_pc1;

  logic            de_v;
  logic [IW-1:0]   de_ins;
  logic [XLEN-1:0] de_pc1, de_a, de_b;

  logic            em_v, em_take;
  logic [2:0]      em_op, em_dest;
  logic [XLEN-1:0] em_res, em_sd, em_tgt, em_pc1;

  logic            mw_v, mw_we;
  logic [2:0]      mw_op, mw_dest;
  logic [XLEN-1:0] mw_data, mw_pc1;

  logic [1:0][XLEN-1:0] id_rd;
  logic [1:0][1:0]      fsel;
  logic [1:0][XLEN-1:0] ex_opnd;
  logic                 ld_stall, flush, stall, halt_id, fetch_off;
  logic [XLEN-1:0]      ex_off, alu_res, alu_tgt;
  logic                 alu_take;

  core_regfile #(.XLEN(XLEN), .NREG(8)) u_rf (
    .clk (clk), .rst_n (rst_n),
    .we  (mw_v && mw_we), .wa (mw_dest), .wd (mw_data),
    .ra  ({f_rb(fd_ins), f_ra(fd_ins)}), .rd (id_rd)
  );

  core_hazard u_hz (
    .fd_v (fd_v), .fd_ra (f_ra(fd_ins)), .fd_rb (f_rb(fd_ins)),
    .de_v (de_v), .de_op (f_op(de_ins)), .de_ra (f_ra(de_ins)), .de_rb (f_rb(de_ins)),
    .em_fwd (em_v && (em_op == OP_ADD || em_op == OP_NAND)), .em_dest (em_dest),
    .mw_fwd (mw_v && mw_we), .mw_dest (mw_dest),
    .ld_stall (ld_stall), .sel (fsel)
  );

  logic [1:0][XLEN-1:0] de_rf;
  assign de_rf[0] = de_a;
  assign de_rf[1] = de_b;

  for (genvar p = 0; p < 2; p++) begin : g_opnd
    assign ex_opnd[p] = (fsel[p] == 2'd1) ? em_res :
                        (fsel[p] == 2'd2) ? mw_data : de_rf[p];
  end

  assign ex_off = {{(XLEN-OFFW){de_ins[OFFW-1]}}, de_ins[OFFW-1:0]};

  core_alu #(.XLEN(XLEN)) u_alu (
    .op (f_op(de_ins)), .a (ex_opnd[0]), .b (ex_opnd[1]), .off (ex_off),
    .pc1 (de_pc1), .res (alu_res), .take (alu_take), .tgt (alu_tgt)
  );

  assign flush     = em_v && em_take;
  assign stall     = ld_stall && !flush;
  assign halt_id   = fd_v && (f_op(fd_ins) == OP_HALT);
  assign fetch_off = halt_id || stop_q;

  // fetch and IF/ID
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0; stop_q <= 1'b0;
      fd_v <= 1'b0; fd_ins <= '0; fd_pc1 <= '0;
    end else if (flush) begin
      pc <= em_tgt; stop_q <= 1'b0; fd_v <= 1'b0;
    end else if (!stall) begin
      if (halt_id) stop_q <= 1'b1;
      if (!fetch_off) pc <= pc + 1'b1;
      fd_v   <= !fetch_off;
      fd_ins <= imem_data;
      fd_pc1 <= pc + 1'b1;
    end
  end

  // ID/EX
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_v <= 1'b0; de_ins <= '0; de_pc1 <= '0; de_a <= '0; de_b <= '0;
    end else if (flush || stall) begin
      de_v <= 1'b0;
    end else begin
      de_v <= fd_v; de_ins <= fd_ins; de_pc1 <= fd_pc1;
      de_a <= id_rd[0]; de_b <= id_rd[1];
    end
  end

  // EX/MEM
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      em_v <= 1'b0; em_take <= 1'b0; em_op <= OP_NOP; em_dest <= '0;
      em_res <= '0; em_sd <= '0; em_tgt <= '0; em_pc1 <= '0;
    end else if (flush) begin
      em_v <= 1'b0;
    end else begin
      em_v    <= de_v;
      em_take <= alu_take;
      em_op   <= f_op(de_ins);
      em_dest <= f_dest(de_ins);
      em_res  <= alu_res;
      em_sd   <= ex_opnd[1];
      em_tgt  <= alu_tgt;
      em_pc1  <= de_pc1;
    end
  end

  assign dmem_en    = em_v && (em_op == OP_LW || em_op == OP_SW);
  assign dmem_we    = em_v && (em_op == OP_SW);
  assign dmem_addr  = em_res;
  assign dmem_wdata = em_sd;

  // MEM/WB
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mw_v <= 1'b0; mw_we <= 1'b0; mw_op <= OP_NOP; mw_dest <= '0;
      mw_data <= '0; mw_pc1 <= '0; done_q <= 1'b0;
    end else begin
      mw_v    <= em_v;
      mw_we   <= em_v && f_wr(em_op);
      mw_op   <= em_op;
      mw_dest <= em_dest;
      mw_data <= (em_op == OP_LW) ? dmem_rdata : em_res;
      mw_pc1  <= em_pc1;
      if (mw_v && mw_op == OP_HALT) done_q <= 1'b1;
    end
  end

  assign imem_addr = pc;
  assign ret_valid = mw_v;
  assign ret_pc    = mw_pc1 - 1'b1;
  assign ret_we    = mw_v && mw_we;
  assign ret_dest  = mw_dest;
  assign ret_data  = mw_data;
  assign done      = done_q || (mw_v && mw_op == OP_HALT);
endmodule

// File: rtl/core_pipe5_chk.sv
module core_pipe5_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flush,
  input logic            stall,
  input logic [XLEN-1:0] pc,
  input logic            fd_v,
  input logic            de_v,
  input logic            em_v,
  input logic            done,
  input logic            ret_valid,
  input logic            ret_we,
  input logic            dmem_en,
  input logic            dmem_we
);
  p_squash_young_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!fd_v && !de_v && !em_v));

  p_stall_hold_pc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (pc == $past(pc)));

  p_stall_bubble_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !de_v);

  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  p_quiet_after_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !ret_valid);

  p_write_needs_retire_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ret_we |-> ret_valid);

  p_store_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> dmem_en);
endmodule

bind core_pipe5 core_pipe5_chk #(.XLEN(XLEN)) u_chk (
  .clk (clk), .rst_n (rst_n), .flush (flush), .stall (stall), .pc (pc),
  .fd_v (fd_v), .de_v (de_v), .em_v (em_v), .done (done),
  .ret_valid (ret_valid), .ret_we (ret_we), .dmem_en (dmem_en), .dmem_we (dmem_we)
);

// File: tb/tb_core_pipe5.sv
`timescale 1ns/1ps
module tb_core_pipe5;
  localparam logic [2:0] K_ADD = 3'd0, K_NAND = 3'd1, K_LW = 3'd2, K_SW = 3'd3,
                         K_BEQ = 3'd4, K_HALT = 3'd6, K_NOP = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, dmem_addr, dmem_wdata, dmem_rdata, ret_pc, ret_data;
  logic [24:0] imem_data;
  logic        dmem_en, dmem_we, ret_valid, ret_we, done;
  logic [2:0]  ret_dest;

  logic [31:0] imem [256];
  logic [31:0] dmem [256];

  always #10 clk = ~clk;

  assign imem_data  = imem[imem_addr[7:0]][24:0];
  assign dmem_rdata = dmem[dmem_addr[7:0]];
  always @(posedge clk) if (dmem_en && dmem_we) dmem[dmem_addr[7:0]] <= dmem_wdata;

  core_pipe5 #(.XLEN(32)) dut (
    .clk (clk), .rst_n (rst_n),
    .imem_addr (imem_addr), .imem_data (imem_data),
    .dmem_en (dmem_en), .dmem_we (dmem_we), .dmem_addr (dmem_addr),
    .dmem_wdata (dmem_wdata), .dmem_rdata (dmem_rdata),
    .ret_valid (ret_valid), .ret_pc (ret_pc), .ret_we (ret_we),
    .ret_dest (ret_dest), .ret_data (ret_data), .done (done)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ir(input logic [2:0] op, input logic [2:0] a,
                                     input logic [2:0] b, input logic [2:0] d);
    return {7'd0, op, a, b, 13'd0, d};
  endfunction

  function automatic logic [31:0] ii(input logic [2:0] op, input logic [2:0] a,
                                     input logic [2:0] b, input int off);
    logic [31:0] o;
    o = off;
    return {7'd0, op, a, b, o[15:0]};
  endfunction

  // reference model state
  logic [31:0] mrf [8];
  logic [31:0] mdm [256];
  logic [31:0] mpc;
  bit          active = 0, first, halted, prev_lw, prev_taken, prev_beq;
  logic [2:0]  prev_dst;
  int          gap;

  task automatic model_step();
    logic [31:0] w, off, v, ea, npc;
    logic [2:0]  op, a, b, d;
    int          eg;
    bit          dep, tk;
    string       gtag;
    w   = imem[mpc[7:0]];
    op  = w[24:22]; a = w[21:19]; b = w[18:16]; d = w[2:0];
    off = {{16{w[15]}}, w[15:0]};
    chk(ret_pc == mpc, "R1 R11", "retire pc", ret_pc, mpc);
    dep = prev_lw && (a == prev_dst || b == prev_dst);
    eg  = 1 + (prev_taken ? 3 : 0) + (dep ? 1 : 0);
    gtag = prev_taken ? "R5" : dep ? "R8" : prev_beq ? "R6" : "R7";
    if (!first) chk(gap == eg, gtag, "retire spacing", gap, eg);
    npc = mpc + 1;
    tk  = 0;
    case (op)
      K_ADD, K_NAND: begin
        v = (op == K_ADD) ? mrf[a] + mrf[b] : ~(mrf[a] & mrf[b]);
        chk(ret_we && ret_dest == d, "R2", "alu dest", {29'd0, ret_dest}, {29'd0, d});
        chk(ret_data == v, "R2 R7 R9 R12", "alu value", ret_data, v);
        mrf[d] = v;
      end
      K_LW: begin
        ea = mrf[a] + off;
        v  = mdm[ea[7:0]];
        chk(ret_we && ret_dest == b, "R3", "load dest", {29'd0, ret_dest}, {29'd0, b});
        chk(ret_data == v, "R3", "load value", ret_data, v);
        mrf[b] = v;
      end
      K_SW: begin
        ea = mrf[a] + off;
        mdm[ea[7:0]] = mrf[b];
        chk(!ret_we, "R4", "store writes no reg", {31'd0, ret_we}, 32'd0);
        chk(dmem[ea[7:0]] == mrf[b], "R4", "stored word", dmem[ea[7:0]], mrf[b]);
      end
      K_BEQ: begin
        tk = (mrf[a] == mrf[b]);
        if (tk) npc = mpc + 1 + off;
        chk(!ret_we, tk ? "R5" : "R6", "branch writes no reg", {31'd0, ret_we}, 32'd0);
      end
      K_HALT: begin
        halted = 1;
        chk(done, "R10", "done at halt retire", {31'd0, done}, 32'd1);
      end
      default: chk(!ret_we, "R11", "no-op writes no reg", {31'd0, ret_we}, 32'd0);
    endcase
    if (op != K_HALT) chk(!done, "R10", "done early", {31'd0, done}, 32'd0);
    prev_lw    = (op == K_LW);
    prev_dst   = b;
    prev_taken = tk;
    prev_beq   = (op == K_BEQ);
    first      = 0;
    mpc        = npc;
  endtask

  always @(negedge clk) begin
    if (active && rst_n) begin
      gap++;
      if (ret_valid) begin
        if (halted) chk(0, "R10", "retire after halt", ret_pc, 32'd0);
        else model_step();
        gap = 0;
      end
    end
  end

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) begin
      imem[i] = ii(K_HALT, 3'd0, 3'd0, 0);
      dmem[i] = 32'd0;
    end
  endtask

  task automatic run_prog();
    int n;
    active = 0;
    rst_n  = 1'b0;
    repeat (3) @(negedge clk);
    chk(!ret_valid, "R12", "reset retire", {31'd0, ret_valid}, 32'd0);
    chk(!done, "R12", "reset done", {31'd0, done}, 32'd0);
    chk(imem_addr == 0, "R12", "reset pc", imem_addr, 32'd0);
    for (int i = 0; i < 8; i++) mrf[i] = 32'd0;
    for (int i = 0; i < 256; i++) mdm[i] = dmem[i];
    mpc = 0; first = 1; halted = 0; prev_lw = 0; prev_taken = 0; prev_beq = 0;
    prev_dst = 0; gap = 0;
    active = 1;
    rst_n  = 1'b1;
    n = 0;
    while (!halted && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (!halted) chk(0, "R10", "program never halted", n, 32'd0);
    repeat (6) begin
      @(negedge clk);
      chk(!ret_valid, "R10", "quiet after halt", {31'd0, ret_valid}, 32'd0);
      chk(done, "R10", "done held", {31'd0, done}, 32'd1);
    end
    active = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R10 watchdog expired actual=%0d expected=0", checks);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // program 1: forwarding, priority, load-use, decode bypass
    clear_mem();
    dmem[0] = 32'd5; dmem[1] = 32'd7; dmem[3] = 32'd100;
    imem[0]  = ir(K_ADD, 3'd6, 3'd7, 3'd5);
    imem[1]  = ii(K_LW, 3'd0, 3'd1, 0);
    imem[2]  = ii(K_LW, 3'd0, 3'd2, 1);
    imem[3]  = ir(K_ADD, 3'd1, 3'd2, 3'd3);
    imem[4]  = ir(K_ADD, 3'd3, 3'd3, 3'd3);
    imem[5]  = ir(K_ADD, 3'd1, 3'd1, 3'd3);
    imem[6]  = ir(K_ADD, 3'd3, 3'd2, 3'd3);
    imem[7]  = ir(K_NAND, 3'd3, 3'd1, 3'd4);
    imem[8]  = ii(K_SW, 3'd0, 3'd4, 10);
    imem[9]  = ii(K_LW, 3'd0, 3'd6, 10);
    imem[10] = ii(K_SW, 3'd0, 3'd6, 11);
    imem[11] = ii(K_LW, 3'd0, 3'd7, 3);
    imem[12] = ii(K_LW, 3'd7, 3'd5, -90);
    imem[13] = ii(K_NOP, 3'd5, 3'd0, 0);
    imem[14] = ir(K_ADD, 3'd2, 3'd2, 3'd1);
    imem[15] = ii(K_NOP, 3'd0, 3'd0, 0);
    imem[16] = ii(K_NOP, 3'd0, 3'd0, 0);
    imem[17] = ir(K_ADD, 3'd1, 3'd0, 3'd2);
    imem[18] = ii(K_HALT, 3'd0, 3'd0, 0);
    imem[19] = ir(K_ADD, 3'd1, 3'd1, 3'd1);
    run_prog();

    // program 2: counted loop, taken and not-taken branches, load before branch
    clear_mem();
    dmem[0] = 32'd3; dmem[1] = 32'hFFFF_FFFF; dmem[2] = 32'd1;
    imem[0]  = ii(K_LW, 3'd0, 3'd1, 0);
    imem[1]  = ii(K_LW, 3'd0, 3'd2, 1);
    imem[2]  = ii(K_LW, 3'd0, 3'd3, 2);
    imem[3]  = ir(K_ADD, 3'd4, 3'd3, 3'd4);
    imem[4]  = ir(K_ADD, 3'd1, 3'd2, 3'd1);
    imem[5]  = ii(K_BEQ, 3'd1, 3'd0, 2);
    imem[6]  = ii(K_BEQ, 3'd0, 3'd0, -4);
    imem[7]  = ir(K_ADD, 3'd3, 3'd3, 3'd5);
    imem[8]  = ii(K_BEQ, 3'd4, 3'd0, 5);
    imem[9]  = ir(K_ADD, 3'd4, 3'd4, 3'd6);
    imem[10] = ii(K_LW, 3'd0, 3'd7, 2);
    imem[11] = ii(K_BEQ, 3'd7, 3'd3, 1);
    imem[12] = ir(K_ADD, 3'd6, 3'd6, 3'd6);
    imem[13] = ii(K_SW, 3'd0, 3'd6, 20);
    imem[14] = ii(K_HALT, 3'd0, 3'd0, 0);
    run_prog();

    // program 3: squashed halt, load-use into a taken branch
    clear_mem();
    dmem[0] = 32'd9; dmem[1] = 32'd9;
    imem[0]  = ii(K_BEQ, 3'd0, 3'd0, 2);
    imem[1]  = ii(K_HALT, 3'd0, 3'd0, 0);
    imem[2]  = ir(K_ADD, 3'd0, 3'd0, 3'd1);
    imem[3]  = ii(K_LW, 3'd0, 3'd1, 0);
    imem[4]  = ii(K_LW, 3'd0, 3'd2, 1);
    imem[5]  = ii(K_BEQ, 3'd1, 3'd2, 2);
    imem[6]  = ii(K_SW, 3'd0, 3'd1, 7);
    imem[7]  = ii(K_HALT, 3'd0, 3'd0, 0);
    imem[8]  = ir(K_ADD, 3'd1, 3'd2, 3'd3);
    imem[9]  = ii(K_SW, 3'd0, 3'd3, 5);
    imem[10] = ii(K_HALT, 3'd0, 3'd0, 0);
    run_prog();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule